// File: doc/BRIEF.md
# Security Code Validator with Attempts Counter

This block decides whether a host has proven knowledge of a 16-bit secret before personalization or protected writes are allowed. The memory sequencer walks an address across the bit map. While the address is inside the code field, the host drives one candidate bit per step, and the block compares it with the stored bit. During these steps the block releases the data line.

The comparison alone grants nothing. To turn a correct code into a granted session, the host must spend an attempt. It first writes a 0 over a live 1 in the attempts counter, then erases that same bit as the very next operation. If every code bit matched, the erase sets the validation flag `sv` and refills the whole 16-bit counter with ones. If any code bit mismatched, the erase leaves the bit consumed. Once the four live counter bits are spent, validation can no longer succeed.

A synchronous sequence reset (`seq_rst`) clears the record of the compare, but keeps `sv`. Only the power-up reset `rst_n` clears `sv` and the counter.

Top module: `scv_validator`

## Requirements
- R1: While `addr` lies in the code field 80..95, `data_oe` is 0. A compare strobe there records a match for bit `addr-80` when `host_bit` equals `stored_bit`.
- R2: A compare strobe in the code field with `host_bit` different from `stored_bit` latches a failure. The failure keeps `sv` from being set until the next `seq_rst` or power-up.
- R3: Validation needs a recorded match for all 16 code bits since the last reset. A compare that leaves out any bit does not validate.
- R4: After power-up all 16 counter bits at addresses 96..111 read 1 and `sv` is 0. A write strobe on a counter bit that reads 1 clears that bit, so `data_out` reads 0 on the next cycle.
- R5: Only a write that clears a live bit (addresses 96..99) arms validation. A write to bits 100..111 arms nothing, and neither does a write to a bit that is already 0. An erase strobe without an armed bit changes nothing.
- R6: An erase strobe on the armed bit, given as the next operation at the same address and with a passing code, sets `sv` one cycle later and refills all 16 counter bits to 1. Moving the address away before the erase disarms.
- R7: An erase on an armed bit while the code has failed leaves that bit at 0 and `sv` unchanged.
- R8: Once bits 96..99 are all 0, no sequence of operations can set `sv`, even with a correct code.
- R9: `sv` stays set across `seq_rst` and is cleared only by `rst_n`. `seq_rst` clears the failure latch and the match record.
- R10: Addresses 16..79 always read `stored_bit` with `data_oe` 1, whatever the value of `sv`.
- R11: A compare strobe outside the code field is ignored. It neither records a failure nor a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| seq_rst | input | 1 | Synchronous sequence reset; clears the compare record only |
| addr | input | 11 | Current bit address from the sequencer |
| stored_bit | input | 1 | Memory content at `addr` |
| host_bit | input | 1 | Bit driven by the host for a compare |
| cmp_en | input | 1 | Compare strobe |
| wr_en | input | 1 | Write (program to 0) strobe |
| er_en | input | 1 | Erase (set to 1) strobe; wins over `wr_en` |
| data_out | output | 1 | Bit returned to the host |
| data_oe | output | 1 | Data output enable |
| sv | output | 1 | Security validated flag |

## Verification
The bench probes several corner cases:
- A code with a single wrong bit. A design that forgets the failure would grant `sv`.
- A code with a bit left out. A design that only looks for mismatches would grant `sv`.
- Writes to non-counting counter bits, and writes to bits that are already 0. A design that arms on any write would validate.
- An address move between the write and the erase. A design without a disarm rule would accept a stale erase.
- An exhausted counter, which must refuse even a correct code.
- A compare strobe outside the field, which must leave the code record untouched.

Retention of `sv` across `seq_rst`, and its loss at power-up, are checked at the ports.

// File: rtl/scv_pkg.sv
package scv_pkg;
  localparam int unsigned SCV_ADDR_W   = 11;
  localparam int unsigned SCV_CODE_LO  = 80;
  localparam int unsigned SCV_CODE_LEN = 16;
  localparam int unsigned SCV_CNT_LO   = 96;
  localparam int unsigned SCV_CNT_LEN  = 16;
  localparam int unsigned SCV_CNT_LIVE = 4;
endpackage

// File: rtl/scv_rst_sync.sv
module scv_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_n_out = hold_q;
endmodule

// File: rtl/scv_code_cmp.sv
module scv_code_cmp #(
  parameter int unsigned ADDR_W   = scv_pkg::SCV_ADDR_W,
  parameter int unsigned CODE_LO  = scv_pkg::SCV_CODE_LO,
  parameter int unsigned CODE_LEN = scv_pkg::SCV_CODE_LEN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seq_rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              stored_bit,
  input  logic              host_bit,
  input  logic              cmp_en,
  output logic              in_code,
  output logic              code_ok
);
  localparam int unsigned IDX_W = (CODE_LEN > 1) ? $clog2(CODE_LEN) : 1;

  logic [ADDR_W-1:0]   off;
  logic [IDX_W-1:0]    idx;
  logic [CODE_LEN-1:0] match_q, match_d;
  logic                fail_q, fail_d;
  logic                cmp_hit;

  always_comb begin
    off     = addr - ADDR_W'(CODE_LO);
    in_code = (off < ADDR_W'(CODE_LEN));
    idx     = off[IDX_W-1:0];
    cmp_hit = cmp_en && in_code;
  end

  // next state: a match sets one mask bit, a mismatch latches failure
  always_comb begin
    match_d = match_q;
    fail_d  = fail_q;
    if (seq_rst) begin
      match_d = '0;
      fail_d  = 1'b0;
    end else if (cmp_hit) begin
      if (host_bit == stored_bit) match_d[idx] = 1'b1;
      else                        fail_d       = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= '0;
      fail_q  <= 1'b0;
    end else begin
      match_q <= match_d;
      fail_q  <= fail_d;
    end
  end

  assign code_ok = (&match_q) && !fail_q;

  // R2: failure stays latched until a sequence reset
  assert_fail_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q && !seq_rst) |=> fail_q);

  // R11: without a compare inside the field the record does not move
  assert_record_still_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_rst && !cmp_hit) |=> ($stable(match_q) && $stable(fail_q)));
endmodule

// File: rtl/scv_attempts.sv
module scv_attempts #(
  parameter int unsigned ADDR_W   = scv_pkg::SCV_ADDR_W,
  parameter int unsigned CNT_LO   = scv_pkg::SCV_CNT_LO,
  parameter int unsigned CNT_LEN  = scv_pkg::SCV_CNT_LEN,
  parameter int unsigned CNT_LIVE = scv_pkg::SCV_CNT_LIVE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seq_rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              er_en,
  input  logic              code_ok,
  output logic              in_cnt,
  output logic              cnt_bit,
  output logic              restore
);
  localparam int unsigned IDX_W = (CNT_LEN > 1) ? $clog2(CNT_LEN) : 1;

  logic [ADDR_W-1:0]  off;
  logic [IDX_W-1:0]   idx;
  logic [CNT_LEN-1:0] cnt_q, cnt_d;
  logic               arm_q, arm_d;
  logic [IDX_W-1:0]   aidx_q, aidx_d;
  logic               same_bit;

  always_comb begin
    off      = addr - ADDR_W'(CNT_LO);
    in_cnt   = (off < ADDR_W'(CNT_LEN));
    idx      = off[IDX_W-1:0];
    same_bit = in_cnt && (idx == aidx_q);
    cnt_bit  = cnt_q[idx];
  end

  // next state: write consumes a 1, erase on the armed bit validates
  always_comb begin
    cnt_d   = cnt_q;
    arm_d   = arm_q;
    aidx_d  = aidx_q;
    restore = 1'b0;
    if (arm_q && !same_bit) arm_d = 1'b0;
    if (er_en && in_cnt) begin
      if (arm_q && same_bit && code_ok) begin
        restore = 1'b1;
        cnt_d   = '1;
      end
      arm_d = 1'b0;
    end else if (wr_en && in_cnt && cnt_q[idx]) begin
      cnt_d[idx] = 1'b0;
      if (idx < IDX_W'(CNT_LIVE)) begin
        arm_d  = 1'b1;
        aidx_d = idx;
      end
    end
    if (seq_rst) arm_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '1;
      arm_q  <= 1'b0;
      aidx_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      arm_q  <= arm_d;
      aidx_q <= aidx_d;
    end
  end

  // R4: without a restore no counter bit ever returns to 1
  assert_no_refill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !restore |=> ((cnt_q & ~$past(cnt_q)) == '0));

  // R5: only a counting bit can be armed
  assert_arm_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
    arm_q |-> (aidx_q < IDX_W'(CNT_LIVE)));

  // R6: an accepted validation leaves a full counter
  assert_refill_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    restore |=> (&cnt_q));
endmodule

// File: rtl/scv_sv_flag.sv
module scv_sv_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_en,
  output logic sv
);
  logic sv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sv_q <= 1'b0;
    else if (set_en) sv_q <= 1'b1;
  end

  assign sv = sv_q;

  // R9: nothing but power-up clears the flag
  assert_sv_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sv_q |=> sv_q);
endmodule

// File: rtl/scv_validator.sv
module scv_validator #(
  parameter int unsigned ADDR_W   = scv_pkg::SCV_ADDR_W,
  parameter int unsigned CODE_LO  = scv_pkg::SCV_CODE_LO,
  parameter int unsigned CODE_LEN = scv_pkg::SCV_CODE_LEN,
  parameter int unsigned CNT_LO   = scv_pkg::SCV_CNT_LO,
  parameter int unsigned CNT_LEN  = scv_pkg::SCV_CNT_LEN,
  parameter int unsigned CNT_LIVE = scv_pkg::SCV_CNT_LIVE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seq_rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              stored_bit,
  input  logic              host_bit,
  input  logic              cmp_en,
  input  logic              wr_en,
  input  logic              er_en,
  output logic              data_out,
  output logic              data_oe,
  output logic              sv
);
  logic rst_ns;
  logic in_code, code_ok;
  logic in_cnt, cnt_bit, restore;

  scv_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_ns)
  );

  scv_code_cmp #(
    .ADDR_W   (ADDR_W),
    .CODE_LO  (CODE_LO),
    .CODE_LEN (CODE_LEN)
  ) u_cmp (
    .clk        (clk),
    .rst_n      (rst_ns),
    .seq_rst    (seq_rst),
    .addr       (addr),
    .stored_bit (stored_bit),
    .host_bit   (host_bit),
    .cmp_en     (cmp_en),
    .in_code    (in_code),
    .code_ok    (code_ok)
  );

  scv_attempts #(
    .ADDR_W   (ADDR_W),
    .CNT_LO   (CNT_LO),
    .CNT_LEN  (CNT_LEN),
    .CNT_LIVE (CNT_LIVE)
  ) u_att (
    .clk     (clk),
    .rst_n   (rst_ns),
    .seq_rst (seq_rst),
    .addr    (addr),
    .wr_en   (wr_en),
    .er_en   (er_en),
    .code_ok (code_ok),
    .in_cnt  (in_cnt),
    .cnt_bit (cnt_bit),
    .restore (restore)
  );

  scv_sv_flag u_sv (
    .clk    (clk),
    .rst_n  (rst_ns),
    .set_en (restore),
    .sv     (sv)
  );

  // data line: released over the code field, counter from local state
  always_comb begin
    data_oe  = !in_code;
    data_out = in_cnt ? cnt_bit : stored_bit;
  end

  // R6: the flag only rises on the cycle after a passing code
  assert_sv_needs_code_R6: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(sv) |-> $past(code_ok));
endmodule

// File: tb/scv_validator_test.sv
module scv_validator_test;
  localparam logic [15:0] CODE = 16'hA5C3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seq_rst = 1'b0;
  logic [10:0] addr = 11'd0;
  logic        stored_bit;
  logic        host_bit = 1'b0;
  logic        cmp_en = 1'b0;
  logic        wr_en = 1'b0;
  logic        er_en = 1'b0;
  logic        data_out, data_oe, sv;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  always_comb begin
    if (addr >= 11'd80 && addr < 11'd96) stored_bit = CODE[addr - 11'd80];
    else                                 stored_bit = addr[0];
  end

  scv_validator uut (
    .clk(clk), .rst_n(rst_n), .seq_rst(seq_rst), .addr(addr),
    .stored_bit(stored_bit), .host_bit(host_bit), .cmp_en(cmp_en),
    .wr_en(wr_en), .er_en(er_en), .data_out(data_out),
    .data_oe(data_oe), .sv(sv)
  );

  // kinds: 0 read, 1 compare, 2 write, 3 erase, 4 seq reset, 5 full good code
  typedef struct packed {
    logic [2:0]  kind;
    logic [10:0] a;
    logic        esv;
    logic        eout;
    logic        eoe;
    logic        cout;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{3'd0, 11'd96,  1'b0, 1'b1, 1'b1, 1'b1},  // R4 reset state of counter
    '{3'd5, 11'd95,  1'b0, 1'b0, 1'b0, 1'b0},  // R1 line released in code field
    '{3'd2, 11'd100, 1'b0, 1'b0, 1'b1, 1'b1},  // R4 write clears a counter bit
    '{3'd3, 11'd100, 1'b0, 1'b0, 1'b1, 1'b1},  // R5 non-counting bit does not arm
    '{3'd2, 11'd96,  1'b0, 1'b0, 1'b1, 1'b1},  // R4 live bit cleared
    '{3'd3, 11'd96,  1'b1, 1'b1, 1'b1, 1'b1},  // R6 erase validates
    '{3'd0, 11'd100, 1'b1, 1'b1, 1'b1, 1'b1},  // R6 whole counter refilled
    '{3'd0, 11'd41,  1'b1, 1'b1, 1'b1, 1'b1}   // R10 issuer zone readable
  };

  task automatic op(input int kind, input int a, input logic flip);
    @(negedge clk);
    addr = 11'(a);
    #1;
    host_bit = stored_bit ^ flip;
    cmp_en   = (kind == 1);
    wr_en    = (kind == 2);
    er_en    = (kind == 3);
    seq_rst  = (kind == 4);
    @(negedge clk);
    cmp_en = 1'b0; wr_en = 1'b0; er_en = 1'b0; seq_rst = 1'b0;
  endtask

  task automatic present(input int bad, input int skip);
    for (int i = 0; i < 16; i++)
      if (i != skip) op(1, 80 + i, (i == bad));
  endtask

  task automatic wr_er(input int a);
    op(2, a, 1'b0);
    op(3, a, 1'b0);
  endtask

  task automatic power_up;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic chk(input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", what, act, exp);
    end
  endtask

  task automatic report;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got hung expected finish");
      report();
    end
  end

  initial begin
    power_up();

    // vector walk
    for (int i = 0; i < 8; i++) begin
      if (VEC[i].kind == 3'd5) present(-1, -1);
      else op(int'(VEC[i].kind), int'(VEC[i].a), 1'b0);
      chk($sformatf("vector %0d sv", i), sv, VEC[i].esv);
      chk($sformatf("vector %0d oe", i), data_oe, VEC[i].eoe);
      if (VEC[i].cout) chk($sformatf("vector %0d out", i), data_out, VEC[i].eout);
    end

    // R9: sequence reset keeps sv, power-up clears it
    op(4, 96, 1'b0);
    chk("R9 sv kept over seq_rst", sv, 1'b1);
    power_up();
    chk("R9 sv cleared by power-up", sv, 1'b0);
    op(0, 40, 1'b0);
    chk("R10 issuer read with sv low", data_out, 1'b0);
    chk("R10 issuer oe with sv low", data_oe, 1'b1);

    // R2 / R7: one wrong code bit
    present(5, -1);
    op(2, 96, 1'b0);
    chk("R7 attempt bit consumed", data_out, 1'b0);
    op(3, 96, 1'b0);
    chk("R2 failed code blocks sv", sv, 1'b0);
    chk("R7 bit stays 0 after failed erase", data_out, 1'b0);

    // R9: seq_rst clears failure, a good code then validates
    op(4, 0, 1'b0);
    present(-1, -1);
    wr_er(97);
    chk("R9 validate after seq_rst", sv, 1'b1);
    op(0, 96, 1'b0);
    chk("R6 refill restores bit 96", data_out, 1'b1);

    // R3: missing code bit
    power_up();
    present(-1, 15);
    wr_er(96);
    chk("R3 incomplete code rejected", sv, 1'b0);

    // R11 and R6 disarm on address move
    power_up();
    present(-1, -1);
    op(1, 50, 1'b1);
    op(2, 97, 1'b0);
    op(0, 98, 1'b0);
    op(3, 97, 1'b0);
    chk("R6 address move disarms", sv, 1'b0);
    wr_er(98);
    chk("R11 stray compare ignored", sv, 1'b1);

    // R8: exhausted counter
    power_up();
    present(3, -1);
    for (int b = 96; b < 100; b++) wr_er(b);
    chk("R7 failed attempts leave sv low", sv, 1'b0);
    op(4, 0, 1'b0);
    present(-1, -1);
    op(2, 96, 1'b0);
    chk("R8 spent bit reads 0", data_out, 1'b0);
    op(3, 96, 1'b0);
    chk("R8 no validation on spent bit", sv, 1'b0);
    wr_er(100);
    chk("R8 no validation via bit 100", sv, 1'b0);

    done = 1'b1;
    report();
  end
endmodule